// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Unit

This sequencer runs the operand phase of a small 8-bit accumulator processor with a 16-bit program counter. An opcode decoder upstream classifies each instruction by addressing style. It hands that class to the unit, together with the branch condition already evaluated and the address of the first byte after the opcode. The unit reads any operand bytes through a byte-wide instruction memory port. It then reports the operand value, or the effective address, and the program counter at which the next instruction begins.

Register-only instructions finish at once with no memory access. Branches read one signed displacement byte and form the destination. Immediate instructions read one or two literal bytes. Zero-page instructions read one byte and use it as the low half of an address whose upper half is zero. The memory port returns data exactly one clock after a read is issued. The unit waits out that clock on every read.

Top module: `opfetch_seq`

## Requirements
- R1: With class code 0 (register-only), `done` rises one clock after the request is accepted. No memory read is issued, `operand` is 0 and `next_pc` equals `pc_in`.
- R2: With class code 1 (branch), exactly one byte is read, from address `pc_in`, and is taken as a signed two's complement displacement in the range -128..+127.
- R3: For a branch, `operand` is (`pc_in` + 1 + sign-extended displacement) mod 2^16. When `cond` is 1, `next_pc` equals that same value.
- R4: For a branch with `cond` = 0, the displacement has no effect on the flow: `next_pc` is (`pc_in` + 1) mod 2^16.
- R5: With class code 2 (one-byte literal), one byte is read from `pc_in`. `operand` is that byte zero-extended, and `next_pc` is `pc_in` + 1.
- R6: With class code 3 (two-byte literal), the high byte is read from `pc_in` and the low byte from `pc_in` + 1, with the address wrapping mod 2^16. `operand` is {high, low} and `next_pc` is `pc_in` + 2.
- R7: With class code 4 (zero-page), one byte B is read from `pc_in`. `operand` is 0x00:B, so that B = 0x55 gives 0x0055, and `next_pc` is `pc_in` + 1.
- R8: Each read holds `mem_rd` high for a single clock, and the data is consumed on the following clock. `done` rises 3 clocks after acceptance for one-byte classes and 5 clocks after acceptance for the two-byte class.
- R9: `done` is a one-clock pulse. `busy` is high from the clock after acceptance through the `done` clock. A `start` seen while `busy` is high is ignored, and so are changes to `mode`, `cond` and `pc_in` during that time.
- R10: A synchronous `rst` forces `busy`, `done` and `mem_rd` low on the next clock and abandons any fetch in progress.
- R11: Unused class codes 5, 6 and 7 behave exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a fetch; taken only when `busy` is low |
| mode | input | 3 | Addressing class code |
| cond | input | 1 | Branch taken flag, sampled at acceptance |
| pc_in | input | 16 | Address of the first byte after the opcode |
| mem_rd | output | 1 | Instruction memory read strobe |
| mem_addr | output | 16 | Instruction memory read address |
| mem_data | input | 8 | Read data, valid one clock after `mem_rd` |
| busy | output | 1 | Fetch in progress or result being presented |
| done | output | 1 | One-clock strobe: `operand` and `next_pc` valid |
| operand | output | 16 | Literal value, branch target or zero-page address |
| next_pc | output | 16 | Address of the next instruction |

## Verification
The bench sweeps every displacement value with the branch flag both set and clear. It does this at program counters close to both ends of the address space, so a design that zero-extends the displacement, uses the opcode address as the sum base, or lets a not-taken branch follow the displacement produces a wrong `next_pc`. Two-byte literals are fetched across the 0xFFFF boundary, which exposes swapped byte order and a design that fails to wrap the read address. The bench also pulses `start` during a fetch and asserts reset midway through one. A unit that re-arms while busy shows a shortened latency or a corrupted operand. A unit that ignores reset keeps `mem_rd` or `busy` high.

// File: rtl/opfetch_seq.sv
module opfetch_seq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic          cond,
  input  logic [2*DW-1:0] pc_in,
  output logic          mem_rd,
  output logic [2*DW-1:0] mem_addr,
  input  logic [DW-1:0] mem_data,
  output logic          busy,
  output logic          done,
  output logic [2*DW-1:0] operand,
  output logic [2*DW-1:0] next_pc
);
  localparam int AW = 2 * DW;
  localparam logic [2:0] M_REL = 3'd1, M_IMM8 = 3'd2, M_IMM16 = 3'd3, M_DIR = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_CAPT} state_t;
  state_t state;

  logic [2:0]    mode_q;
  logic          cond_q;
  logic          second_q;
  logic [DW-1:0] hi_q;
  logic [AW-1:0] ptr, base_pc;

  logic needs_read, accept, last_byte;
  logic [AW-1:0] ptr_nx, rel_tgt;

  assign needs_read = (mode == M_REL) || (mode == M_IMM8) || (mode == M_IMM16) || (mode == M_DIR);
  assign accept     = start && (state == S_IDLE) && !done;
  assign last_byte  = !(mode_q == M_IMM16 && !second_q);
  assign ptr_nx     = ptr + 1'b1;
  assign rel_tgt    = ptr_nx + {{(AW-DW){mem_data[DW-1]}}, mem_data};

  assign mem_rd   = (state == S_FETCH);
  assign mem_addr = ptr;
  assign busy     = (state != S_IDLE) || done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      done     <= 1'b0;
      mode_q   <= '0;
      cond_q   <= 1'b0;
      second_q <= 1'b0;
      hi_q     <= '0;
      ptr      <= '0;
      base_pc  <= '0;
      operand  <= '0;
      next_pc  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          mode_q   <= mode;
          cond_q   <= cond;
          base_pc  <= pc_in;
          ptr      <= pc_in;
          second_q <= 1'b0;
          if (needs_read) state <= S_FETCH;
          else begin
            done    <= 1'b1;
            operand <= '0;
            next_pc <= pc_in;
          end
        end
        S_FETCH: state <= S_CAPT;
        S_CAPT: begin
          ptr <= ptr_nx;
          if (!last_byte) begin
            hi_q     <= mem_data;
            second_q <= 1'b1;
            state    <= S_FETCH;
          end else begin
            state   <= S_IDLE;
            done    <= 1'b1;
            next_pc <= ptr_nx;
            case (mode_q)
              M_REL: begin
                operand <= rel_tgt;
                if (cond_q) next_pc <= rel_tgt;
              end
              M_IMM16: operand <= {hi_q, mem_data};
              default: operand <= {{(AW-DW){1'b0}}, mem_data};
            endcase
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_INH_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (accept && !needs_read) |=> (done && !mem_rd)); // R1
  AST_REL_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (done && mode_q == M_REL && !cond_q) |-> (next_pc == base_pc + 1'b1)); // R4
  AST_DIR_PAGE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && mode_q == M_DIR) |-> (operand[AW-1:DW] == '0)); // R7
  AST_READ_SPACED: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(base_pc)); // R9
endmodule

// File: tb/opfetch_seq_bench.sv
module opfetch_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic        cond = 1'b0;
  logic [15:0] pc_in = '0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data = '0;
  logic        busy, done;
  logic [15:0] operand, next_pc;
  logic [7:0]  seed_r = '0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  opfetch_seq u_opfetch_seq (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .cond(cond), .pc_in(pc_in),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
    .busy(busy), .done(done), .operand(operand), .next_pc(next_pc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a, input logic [7:0] s);
    return {a[3:0], a[7:4]} ^ a[15:8] ^ s;
  endfunction

  always @(posedge clk) if (mem_rd) mem_data <= memf(mem_addr, seed_r);

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 190000);
      finish_up();
    end
  end

  task automatic run(input logic [2:0] m, input logic c, input logic [15:0] pc,
                     input logic [7:0] s, input bit poke);
    logic [15:0] addrs[4];
    int nrd, lat, exp_nrd, exp_lat;
    logic [7:0] b0, b1;
    logic [15:0] tgt, e_op, e_np;
    string rq;
    b0 = memf(pc, s);
    b1 = memf(pc + 16'd1, s);
    tgt = pc + 16'd1 + {{8{b0[7]}}, b0};
    case (m)
      3'd1: begin exp_nrd = 1; e_op = tgt; e_np = c ? tgt : pc + 16'd1; rq = c ? "R3" : "R4"; end
      3'd2: begin exp_nrd = 1; e_op = {8'h00, b0}; e_np = pc + 16'd1; rq = "R5"; end
      3'd3: begin exp_nrd = 2; e_op = {b0, b1}; e_np = pc + 16'd2; rq = "R6"; end
      3'd4: begin exp_nrd = 1; e_op = {8'h00, b0}; e_np = pc + 16'd1; rq = "R7"; end
      3'd0: begin exp_nrd = 0; e_op = 16'h0; e_np = pc; rq = "R1"; end
      default: begin exp_nrd = 0; e_op = 16'h0; e_np = pc; rq = "R11"; end
    endcase
    exp_lat = (exp_nrd == 0) ? 1 : (exp_nrd == 1 ? 3 : 5);
    @(negedge clk);
    mode = m; cond = c; pc_in = pc; seed_r = s; start = 1'b1;
    nrd = 0;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      if (mem_rd) begin
        if (nrd < 4) addrs[nrd] = mem_addr;
        nrd++;
      end
      if (poke && lat == 2) begin
        start = 1'b1; mode = 3'd0; cond = ~c; pc_in = pc ^ 16'h5A5A;
      end else start = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    chk(lat == exp_lat, "R8 latency", lat, exp_lat);
    chk(nrd == exp_nrd, (m == 3'd0) ? "R1 read count" : "R2 read count", nrd, exp_nrd);
    if (nrd >= 1 && exp_nrd >= 1) chk(addrs[0] == pc, "R2 first read address", addrs[0], pc);
    if (nrd >= 2 && exp_nrd == 2) chk(addrs[1] == pc + 16'd1, "R6 second read address", addrs[1], pc + 16'd1);
    chk(operand == e_op, {rq, " operand"}, operand, e_op);
    chk(next_pc == e_np, {rq, " next_pc"}, next_pc, e_np);
    chk(busy, "R9 busy during done", busy, 1);
    @(negedge clk);
    chk(!done && !busy, "R9 done one clock", {done, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd, "R10 reset state", {busy, done, mem_rd}, 0);
    rst = 1'b0;

    foreach (mode[i]) ;
    for (int m = 0; m < 8; m++)
      if (m == 0 || m >= 5)
        for (int k = 0; k < 3; k++)
          run(m[2:0], k[0], (k == 0) ? 16'h0000 : (k == 1 ? 16'h1234 : 16'hFFFF), 8'h00, 1'b0);

    for (int p = 0; p < 5; p++) begin
      logic [15:0] pc;
      case (p)
        0: pc = 16'h0000; 1: pc = 16'h1000; 2: pc = 16'hFFFE; 3: pc = 16'hFF80; default: pc = 16'h007F;
      endcase
      for (int off = 0; off < 256; off++)
        for (int c = 0; c < 2; c++)
          run(3'd1, c[0], pc, off[7:0] ^ memf(pc, 8'h00), 1'b0);
    end

    for (int p = 0; p < 64; p++)
      for (int s = 0; s < 4; s++) begin
        logic [15:0] pc;
        pc = (p < 32) ? p[15:0] * 16'd1031 : 16'hFFFF - p[15:0] + 16'd32;
        run(3'd2, 1'b0, pc, s[7:0] * 8'd67, 1'b0);
        run(3'd4, 1'b1, pc, s[7:0] * 8'd67 + 8'd5, 1'b0);
        run(3'd3, 1'b0, pc, s[7:0] * 8'd67 + 8'd9, 1'b0);
      end

    run(3'd4, 1'b0, 16'h0300, 8'h55 ^ memf(16'h0300, 8'h00), 1'b0);
    run(3'd3, 1'b0, 16'hFFFF, 8'hA5, 1'b0);
    run(3'd3, 1'b1, 16'h2222, 8'h3C, 1'b1);
    run(3'd1, 1'b0, 16'h4000, 8'h80 ^ memf(16'h4000, 8'h00), 1'b1);

    @(negedge clk);
    mode = 3'd3; pc_in = 16'h0800; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_rd, "R10 mid-fetch reset", {busy, done, mem_rd}, 0);
    rst = 1'b0;
    run(3'd2, 1'b0, 16'h0801, 8'h11, 1'b0);

    finish_up();
  end
endmodule